// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block is the exception entry sequencer of the system-control coprocessor in a pipelined RISC core with branch delay slots. Each cycle it samples a vector of fault requests, a reset request and their side data: the load/store flag, the faulting address, the coprocessor number, the address-space identifier, the exception base address and the interrupt-vector mode. It also samples the current values of the control registers it depends on. If any request is present, the next cycle carries the new values and write strobes for the status, cause, exception-PC, shadow-set, bad-address, translation-high and context registers. The same cycle carries the three-deep PC chain that starts the handler, together with a one-cycle `done` pulse.

The register file that holds the control registers lives outside this block. It applies each group of outputs when the matching write strobe is high. The fetch stage loads `pc_o`, `npc_o` and `nnpc_o` when `done` is high. The design handles priority among simultaneous requests, detection of a fault in a delay slot, gating of the shadow-set swap, and the choice of handler vector.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Every cycle in which `req_reset` or any bit of `req_fault` is high is followed, one clock later, by a single-cycle `done` pulse and the matching outputs. A cycle with no request gives `done`=0 and all write strobes 0 in the next cycle.
- R2: `req_reset` wins over all faults. Among fault bits the lowest index wins. The bit map is: 0 interrupt, 1 TLB modified, 2 TLB refill, 3 TLB invalid, 4 address error, 5 syscall, 6 breakpoint, 7 reserved instruction, 8 coprocessor unusable, 9 overflow, 10 trap.
- R3: On a fault, `cause_exc` receives the code of the winning fault: interrupt 0, TLB modified 1, TLB refill or invalid 2 for a load and 3 for a store, address error 4 for a load and 5 for a store, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13.
- R4: A fault is in a delay slot when `cur_pc`+4 differs from `cur_npc`. In that case `epc` is `cur_pc`-4 and `cause_bd` is 1. Otherwise `epc` is `cur_pc` and `cause_bd` is 0. `exc_we` commits both.
- R5: Every fault entry drives `status_we`=1 and `status_exl`=1, whatever the previous EXL value was.
- R6: `srs_we` is 1 only on a fault sampled with `cur_exl`=0 and `cur_bev`=0. It then gives `srs_pss`=`cur_css` and `srs_css`=`cur_ess`.
- R7: The general handler is `ebase`+0x180. An overflow sampled with `cur_bev`=1 goes instead to the fixed address 0xBFC00200.
- R8: A TLB refill goes to `ebase`+0x000 when the sampled `cur_exl` was 0, and to `ebase`+0x180 when it was 1.
- R9: An interrupt goes to `ebase`+0x200 when `ivec_mode`=1, and to `ebase`+0x180 otherwise.
- R10: Whenever `done` is 1, `npc_o`=`pc_o`+4 and `nnpc_o`=`pc_o`+8.
- R11: TLB modified, refill and invalid faults raise `badva_we` and `tlbctx_we`. They set `badva`=`fault_addr`, `ehi_vpn2` and `ctx_badvpn2` to `fault_addr`[31:13], and `ehi_asid`=`asid_in`. Address error raises `badva_we` only. All other faults raise neither strobe.
- R12: A reset request gives `pc_o`=0xBFC00000, `status_we`=1, `status_cu1`=1 and `status_exl`=`cur_exl`. It raises neither `exc_we` nor `srs_we`.
- R13: On a fault, `cause_ce` is `cop_id` for coprocessor unusable and `cur_ce` for every other fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Reset entry request |
| req_fault | input | 11 | Fault request bits (map in R2) |
| is_store | input | 1 | Faulting access was a store |
| fault_addr | input | 32 | Faulting virtual address |
| cop_id | input | 2 | Coprocessor number for unusable fault |
| asid_in | input | 8 | Address-space identifier of the access |
| ebase | input | 32 | Exception base address |
| ivec_mode | input | 1 | Dedicated interrupt vector enabled |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_npc | input | 32 | Next PC at fault time |
| cur_exl | input | 1 | Current exception-level bit |
| cur_bev | input | 1 | Current boot-vector bit |
| cur_cu1 | input | 1 | Current coprocessor-1 usable bit |
| cur_ce | input | 2 | Current coprocessor-error field |
| cur_css | input | 4 | Current shadow set |
| cur_ess | input | 4 | Exception shadow set |
| done | output | 1 | Entry complete; PC chain valid |
| pc_o | output | 32 | New PC |
| npc_o | output | 32 | New next PC |
| nnpc_o | output | 32 | New next-next PC |
| status_we | output | 1 | Status write strobe |
| status_exl | output | 1 | New exception-level bit |
| status_cu1 | output | 1 | New coprocessor-1 usable bit |
| exc_we | output | 1 | Cause and EPC write strobe |
| cause_bd | output | 1 | Delay-slot flag |
| cause_exc | output | 5 | Exception code |
| cause_ce | output | 2 | Coprocessor-error field |
| epc | output | 32 | Exception return PC |
| srs_we | output | 1 | Shadow-set control write strobe |
| srs_pss | output | 4 | New previous shadow set |
| srs_css | output | 4 | New current shadow set |
| badva_we | output | 1 | Bad-address write strobe |
| badva | output | 32 | Bad virtual address |
| tlbctx_we | output | 1 | Translation-high and context write strobe |
| ehi_vpn2 | output | 19 | New VPN2 of translation-high |
| ehi_asid | output | 8 | New ASID of translation-high |
| ctx_badvpn2 | output | 19 | New bad VPN2 of context |

## Verification
The bench drives random single-bit fault requests with random load/store flags, EXL, BEV and vector-mode settings. Each run separates the exception-code table, the three vector choices and which register groups are written. Multi-bit request vectors, some with reset added, show whether precedence follows the bit order and whether reset wins. Next-PC values are set either sequential or to a random branch target, which separates delay-slot faults from normal faults in `epc` and `cause_bd`. Directed cases cover overflow with BEV set, refill with EXL clear and set, and both interrupt modes, each of which reaches a vector that random runs hit only rarely.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NKIND  = 11;
  localparam int KIND_W = $clog2(NKIND);
  localparam int CODE_W = 5;

  // Bit index in the request vector doubles as precedence (lower wins).
  typedef enum logic [KIND_W-1:0] {
    K_INT     = 4'd0,
    K_TMOD    = 4'd1,
    K_TREFILL = 4'd2,
    K_TINV    = 4'd3,
    K_ADERR   = 4'd4,
    K_SYS     = 4'd5,
    K_BRK     = 4'd6,
    K_RSV     = 4'd7,
    K_CPU     = 4'd8,
    K_OVF     = 4'd9,
    K_TRAP    = 4'd10
  } kind_e;

  function automatic logic [CODE_W-1:0] code_of(kind_e k, logic st);
    logic [CODE_W-1:0] c;
    case (k)
      K_INT:            c = 5'd0;
      K_TMOD:           c = 5'd1;
      K_TREFILL, K_TINV: c = st ? 5'd3 : 5'd2;
      K_ADERR:          c = st ? 5'd5 : 5'd4;
      K_SYS:            c = 5'd8;
      K_BRK:            c = 5'd9;
      K_RSV:            c = 5'd10;
      K_CPU:            c = 5'd11;
      K_OVF:            c = 5'd12;
      K_TRAP:           c = 5'd13;
      default:          c = 5'd0;
    endcase
    return c;
  endfunction

  function automatic logic is_tlb(kind_e k);
    return (k == K_TMOD) || (k == K_TREFILL) || (k == K_TINV);
  endfunction

endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int N = 11,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx
);
  // Scan from the top so the lowest set bit is the last one kept.
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/exc_slot.sv
module exc_slot #(
  parameter int XLEN  = 32,
  parameter int INSTB = 4
) (
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_npc,
  output logic            in_slot,
  output logic [XLEN-1:0] ret_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTB);

  always_comb begin
    in_slot = (cur_pc + STEP) != cur_npc;
    ret_pc  = in_slot ? (cur_pc - STEP) : cur_pc;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] OVF_BOOT   = 32'hBFC0_0200,
  parameter int              GEN_OFS    = 'h180,
  parameter int              IRQ_OFS    = 'h200,
  parameter int              REFILL_OFS = 'h000
) (
  input  kind_e           kind,
  input  logic [XLEN-1:0] ebase,
  input  logic            exl_before,
  input  logic            bev,
  input  logic            ivec_mode,
  output logic [XLEN-1:0] handler
);
  logic [XLEN-1:0] gen_vec;

  always_comb begin
    gen_vec = ebase + XLEN'(GEN_OFS);
    case (kind)
      K_TREFILL: handler = exl_before ? gen_vec : (ebase + XLEN'(REFILL_OFS));
      K_INT:     handler = ivec_mode ? (ebase + XLEN'(IRQ_OFS)) : gen_vec;
      K_OVF:     handler = bev ? OVF_BOOT : gen_vec;
      default:   handler = gen_vec;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              ASID_W    = 8,
  parameter int              SET_W     = 4,
  parameter int              CE_W      = 2,
  parameter int              PAGE_LSB  = 13,
  parameter int              INSTB     = 4,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] OVF_BOOT  = 32'hBFC0_0200,
  localparam int             VPN2_W    = XLEN - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic [NKIND-1:0]  req_fault,
  input  logic              is_store,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic [CE_W-1:0]   cop_id,
  input  logic [ASID_W-1:0] asid_in,
  input  logic [XLEN-1:0]   ebase,
  input  logic              ivec_mode,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_npc,
  input  logic              cur_exl,
  input  logic              cur_bev,
  input  logic              cur_cu1,
  input  logic [CE_W-1:0]   cur_ce,
  input  logic [SET_W-1:0]  cur_css,
  input  logic [SET_W-1:0]  cur_ess,
  output logic              done,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic [XLEN-1:0]   nnpc_o,
  output logic              status_we,
  output logic              status_exl,
  output logic              status_cu1,
  output logic              exc_we,
  output logic              cause_bd,
  output logic [CODE_W-1:0] cause_exc,
  output logic [CE_W-1:0]   cause_ce,
  output logic [XLEN-1:0]   epc,
  output logic              srs_we,
  output logic [SET_W-1:0]  srs_pss,
  output logic [SET_W-1:0]  srs_css,
  output logic              badva_we,
  output logic [XLEN-1:0]   badva,
  output logic              tlbctx_we,
  output logic [VPN2_W-1:0] ehi_vpn2,
  output logic [ASID_W-1:0] ehi_asid,
  output logic [VPN2_W-1:0] ctx_badvpn2
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTB);

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // Submodules
  logic              any_fault;
  logic [NKIND-1:0]  grant;
  logic [KIND_W-1:0] win_idx;
  kind_e             kind;
  logic              in_slot;
  logic [XLEN-1:0]   ret_pc;
  logic [XLEN-1:0]   vec_addr;

  exc_pick #(.N(NKIND)) u_pick (
    .req   (req_fault),
    .any   (any_fault),
    .grant (grant),
    .idx   (win_idx)
  );

  assign kind = kind_e'(win_idx);

  exc_slot #(.XLEN(XLEN), .INSTB(INSTB)) u_slot (
    .cur_pc  (cur_pc),
    .cur_npc (cur_npc),
    .in_slot (in_slot),
    .ret_pc  (ret_pc)
  );

  exc_vector #(.XLEN(XLEN), .OVF_BOOT(OVF_BOOT)) u_vec (
    .kind       (kind),
    .ebase      (ebase),
    .exl_before (cur_exl),
    .bev        (cur_bev),
    .ivec_mode  (ivec_mode),
    .handler    (vec_addr)
  );

  // Next-state logic
  logic              fault_go, act;
  logic [XLEN-1:0]   nxt_pc;
  logic              nxt_exl, nxt_cu1;
  logic              nxt_srs_we, nxt_badva_we, nxt_tlb_we;
  logic [CODE_W-1:0] nxt_code;
  logic [CE_W-1:0]   nxt_ce;

  always_comb begin
    fault_go     = any_fault && !req_reset;
    act          = req_reset || any_fault;
    nxt_pc       = req_reset ? RESET_VEC : vec_addr;
    nxt_exl      = req_reset ? cur_exl : 1'b1;
    nxt_cu1      = req_reset ? 1'b1 : cur_cu1;
    nxt_code     = code_of(kind, is_store);
    nxt_ce       = (kind == K_CPU) ? cop_id : cur_ce;
    nxt_srs_we   = fault_go && !cur_exl && !cur_bev;
    nxt_tlb_we   = fault_go && is_tlb(kind);
    nxt_badva_we = nxt_tlb_we || (fault_go && (kind == K_ADERR));
  end

  // Strobes: every cycle
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      done      <= 1'b0;
      status_we <= 1'b0;
      exc_we    <= 1'b0;
      srs_we    <= 1'b0;
      badva_we  <= 1'b0;
      tlbctx_we <= 1'b0;
    end else begin
      done      <= act;
      status_we <= act;
      exc_we    <= fault_go;
      srs_we    <= nxt_srs_we;
      badva_we  <= nxt_badva_we;
      tlbctx_we <= nxt_tlb_we;
    end
  end

  // Data: loaded under explicit enables
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pc_o       <= '0;
      npc_o      <= '0;
      nnpc_o     <= '0;
      status_exl <= 1'b0;
      status_cu1 <= 1'b0;
    end else if (act) begin
      pc_o       <= nxt_pc;
      npc_o      <= nxt_pc + STEP;
      nnpc_o     <= nxt_pc + (STEP << 1);
      status_exl <= nxt_exl;
      status_cu1 <= nxt_cu1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cause_bd  <= 1'b0;
      cause_exc <= '0;
      cause_ce  <= '0;
      epc       <= '0;
    end else if (fault_go) begin
      cause_bd  <= in_slot;
      cause_exc <= nxt_code;
      cause_ce  <= nxt_ce;
      epc       <= ret_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      srs_pss <= '0;
      srs_css <= '0;
    end else if (nxt_srs_we) begin
      srs_pss <= cur_css;
      srs_css <= cur_ess;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      badva <= '0;
    end else if (nxt_badva_we) begin
      badva <= fault_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ehi_vpn2    <= '0;
      ehi_asid    <= '0;
      ctx_badvpn2 <= '0;
    end else if (nxt_tlb_we) begin
      ehi_vpn2    <= fault_addr[XLEN-1:PAGE_LSB];
      ehi_asid    <= asid_in;
      ctx_badvpn2 <= fault_addr[XLEN-1:PAGE_LSB];
    end
  end

  // Assertions
  p_done_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_reset || (|req_fault)) |=> done);
  p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    !(req_reset || (|req_fault)) |=> (!done && !exc_we && !status_we));
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(grant) && ((grant & ~req_fault) == '0) && ((|req_fault) == (|grant)));
  p_reset_wins_r12: assert property (@(posedge clk) disable iff (!rst_ok)
    req_reset |=> (!exc_we && !srs_we && pc_o == RESET_VEC));
  p_slot_epc_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    exc_we |-> (cause_bd == (($past(cur_pc) + STEP) != $past(cur_npc))) &&
               (epc == (cause_bd ? $past(cur_pc) - STEP : $past(cur_pc))));
  p_exl_set_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    exc_we |-> (status_we && status_exl));
  p_srs_gate_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    srs_we |-> (!$past(cur_exl) && !$past(cur_bev) && exc_we));
  p_chain_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> (npc_o == pc_o + STEP) && (nnpc_o == pc_o + (STEP << 1)));
  p_badva_tlb_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    tlbctx_we |-> (badva_we && exc_we && badva[XLEN-1:PAGE_LSB] == ehi_vpn2));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/100ps
module exc_entry_ctrl_tb;
  localparam int NK = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_reset;
  logic [NK-1:0] req_fault;
  logic        is_store, ivec_mode, cur_exl, cur_bev, cur_cu1;
  logic [31:0] fault_addr, ebase, cur_pc, cur_npc;
  logic [1:0]  cop_id, cur_ce;
  logic [7:0]  asid_in;
  logic [3:0]  cur_css, cur_ess;
  logic        done, status_we, status_exl, status_cu1, exc_we, cause_bd;
  logic        srs_we, badva_we, tlbctx_we;
  logic [31:0] pc_o, npc_o, nnpc_o, epc, badva;
  logic [4:0]  cause_exc;
  logic [1:0]  cause_ce;
  logic [3:0]  srs_pss, srs_css;
  logic [18:0] ehi_vpn2, ctx_badvpn2;
  logic [7:0]  ehi_asid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_fault(req_fault),
    .is_store(is_store), .fault_addr(fault_addr), .cop_id(cop_id),
    .asid_in(asid_in), .ebase(ebase), .ivec_mode(ivec_mode),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_exl(cur_exl), .cur_bev(cur_bev),
    .cur_cu1(cur_cu1), .cur_ce(cur_ce), .cur_css(cur_css), .cur_ess(cur_ess),
    .done(done), .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .status_we(status_we), .status_exl(status_exl), .status_cu1(status_cu1),
    .exc_we(exc_we), .cause_bd(cause_bd), .cause_exc(cause_exc),
    .cause_ce(cause_ce), .epc(epc), .srs_we(srs_we), .srs_pss(srs_pss),
    .srs_css(srs_css), .badva_we(badva_we), .badva(badva),
    .tlbctx_we(tlbctx_we), .ehi_vpn2(ehi_vpn2), .ehi_asid(ehi_asid),
    .ctx_badvpn2(ctx_badvpn2)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] ref_code(int w, logic st);
    case (w)
      0: return 5'd0;   1: return 5'd1;
      2, 3: return st ? 5'd3 : 5'd2;
      4: return st ? 5'd5 : 5'd4;
      5: return 5'd8;   6: return 5'd9;   7: return 5'd10;
      8: return 5'd11;  9: return 5'd12;  default: return 5'd13;
    endcase
  endfunction

  function automatic logic [31:0] ref_vec(int w);
    case (w)
      2: return cur_exl ? ebase + 32'h180 : ebase;
      0: return ivec_mode ? ebase + 32'h200 : ebase + 32'h180;
      9: return cur_bev ? 32'hBFC0_0200 : ebase + 32'h180;
      default: return ebase + 32'h180;
    endcase
  endfunction

  function automatic string vec_tag(int w);
    case (w)
      2: return "R8";
      0: return "R9";
      default: return "R7";
    endcase
  endfunction

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step_and_check(bit multi);
    int w;
    logic rs;
    logic [NK-1:0] rq;
    logic [31:0] x_pc, x_epc;
    logic x_bd, x_srs;
    logic [31:0] s_addr, s_pc;
    logic [7:0] s_asid;
    logic [3:0] s_css, s_ess;
    logic [1:0] s_ce, s_cop;
    logic s_st, s_exl, s_cu1;
    w = -1;
    rs = req_reset; rq = req_fault;
    for (int i = NK - 1; i >= 0; i--) if (rq[i]) w = i;
    x_pc  = rs ? 32'hBFC0_0000 : ref_vec(w);
    x_bd  = (cur_pc + 32'd4) != cur_npc;
    x_epc = x_bd ? cur_pc - 32'd4 : cur_pc;
    x_srs = !rs && (w >= 0) && !cur_exl && !cur_bev;
    s_addr = fault_addr; s_pc = cur_pc; s_asid = asid_in;
    s_css = cur_css; s_ess = cur_ess; s_ce = cur_ce; s_cop = cop_id;
    s_st = is_store; s_exl = cur_exl; s_cu1 = cur_cu1;
    @(posedge clk);
    @(negedge clk);
    if (!rs && w < 0) begin
      chk("R1 idle done", {31'd0, done}, 32'd0);
      chk("R1 idle strobes", {28'd0, status_we, exc_we, srs_we, badva_we}, 32'd0);
    end else if (rs) begin
      chk("R1 done", {31'd0, done}, 32'd1);
      chk(multi ? "R2 R12 reset pc" : "R12 reset pc", pc_o, x_pc);
      chk("R12 cu1/exl", {30'd0, status_we, status_cu1}, 32'd3);
      chk("R12 exl kept", {31'd0, status_exl}, {31'd0, s_exl});
      chk("R12 no exc/srs write", {30'd0, exc_we, srs_we}, 32'd0);
      chk("R10 chain", npc_o - pc_o + (nnpc_o - pc_o), 32'd12);
    end else begin
      chk("R1 done", {31'd0, done}, 32'd1);
      chk(multi ? "R2 code" : "R3 code", {27'd0, cause_exc}, {27'd0, ref_code(w, s_st)});
      chk(vec_tag(w), pc_o, x_pc);
      chk("R10 npc", npc_o, x_pc + 32'd4);
      chk("R10 nnpc", nnpc_o, x_pc + 32'd8);
      chk("R4 bd", {31'd0, cause_bd}, {31'd0, x_bd});
      chk("R4 epc", epc, x_epc);
      chk("R5 exl", {29'd0, exc_we, status_we, status_exl}, 32'd7);
      chk("R5 cu1 kept", {31'd0, status_cu1}, {31'd0, s_cu1});
      chk("R6 srs_we", {31'd0, srs_we}, {31'd0, x_srs});
      if (x_srs) chk("R6 sets", {24'd0, srs_pss, srs_css}, {24'd0, s_css, s_ess});
      chk("R13 ce", {30'd0, cause_ce}, {30'd0, (w == 8) ? s_cop : s_ce});
      chk("R11 strobes", {30'd0, badva_we, tlbctx_we},
          {30'd0, (w >= 1 && w <= 4), (w >= 1 && w <= 3)});
      if (w >= 1 && w <= 4) chk("R11 badva", badva, s_addr);
      if (w >= 1 && w <= 3) begin
        chk("R11 vpn2", {13'd0, ehi_vpn2}, {13'd0, s_addr[31:13]});
        chk("R11 ctx", {13'd0, ctx_badvpn2}, {13'd0, s_addr[31:13]});
        chk("R11 asid", {24'd0, ehi_asid}, {24'd0, s_asid});
      end
    end
    if (s_pc === 32'hx) $display("unreachable");
  endtask

  task automatic rand_side();
    is_store   = 1'($urandom);
    fault_addr = $urandom;
    cop_id     = 2'($urandom);
    asid_in    = 8'($urandom);
    ebase      = {2'b10, 18'($urandom), 12'h000};
    ivec_mode  = 1'($urandom);
    cur_pc     = {$urandom} & 32'hFFFF_FFFC;
    cur_npc    = ($urandom % 2) ? cur_pc + 32'd4 : ({$urandom} & 32'hFFFF_FFFC);
    cur_exl    = 1'($urandom);
    cur_bev    = ($urandom % 4) == 0;
    cur_cu1    = 1'($urandom);
    cur_ce     = 2'($urandom);
    cur_css    = 4'($urandom);
    cur_ess    = 4'($urandom);
  endtask

  task automatic one_fault(int k);
    req_reset = 1'b0;
    req_fault = '0;
    req_fault[k] = 1'b1;
    step_and_check(1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_reset = 1'b0;
    req_fault = '0;
    rand_side();
    repeat (3) @(negedge clk);
    chk("R1 reset state done", {31'd0, done}, 32'd0);
    chk("R1 reset state strobes", {26'd0, status_we, exc_we, srs_we, badva_we, tlbctx_we, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corners
    rand_side(); cur_bev = 1'b1; one_fault(9);                 // R7 boot overflow
    rand_side(); cur_bev = 1'b0; one_fault(9);                 // R7
    rand_side(); cur_exl = 1'b0; one_fault(2);                 // R8
    rand_side(); cur_exl = 1'b1; one_fault(2);                 // R8
    rand_side(); ivec_mode = 1'b1; one_fault(0);               // R9
    rand_side(); ivec_mode = 1'b0; one_fault(0);               // R9
    rand_side(); cur_exl = 1'b0; cur_bev = 1'b0; one_fault(5); // R6 swap
    rand_side(); cur_npc = cur_pc + 32'd4; one_fault(6);       // R4 no slot
    rand_side(); cur_npc = cur_pc + 32'd64; one_fault(6);      // R4 slot
    rand_side(); cop_id = 2'd3; one_fault(8);                  // R13
    rand_side(); req_reset = 1'b1; req_fault = '1; step_and_check(1'b1); // R2 R12
    rand_side(); req_reset = 1'b0; req_fault = 11'b101_0001_1000; step_and_check(1'b1); // R2

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      bit multi;
      rand_side();
      r = $urandom % 100;
      multi = 1'b0;
      req_reset = 1'b0;
      req_fault = '0;
      if (r < 65) req_fault[$urandom % NK] = 1'b1;
      else if (r < 85) begin req_fault = NK'($urandom); multi = 1'b1; end
      else if (r < 92) begin req_reset = 1'b1; req_fault = NK'($urandom); multi = 1'b1; end
      step_and_check(multi);
    end

    req_reset = 1'b0; req_fault = '0;
    step_and_check(1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule